// File: doc/BRIEF.md
# Decimal-Setpoint Pulse-Width Modulator

This block drives a single digital line with a pulse train of fixed period and adjustable high time. The period is exactly one hundred input clocks. It is built from two chained decade counters: the units digit steps on every clock, and the tens digit steps when the units digit rolls over. The high time is chosen in whole percent by a two-digit decimal setpoint. Each digit arrives as a 4-bit BCD code. A setpoint of N keeps the line high for N clocks of every hundred. If a 2.5 MHz clock drives the block, the line toggles at 25 kHz.

The output comes from a set/clear flip-flop rather than from a magnitude comparator. The counter rolling over from 99 to 00 sets the flip-flop. The counter reaching the setpoint clears it, and clear wins when both happen together. The setpoint is captured only at the start of each period, and any digit above nine is reduced to nine as it is captured. The block also provides an inverted copy of the line and a one-clock strobe that marks each period start, for timing downstream logic.

Top module: `pwm_bcd_gen`

## Requirements
- R1: Consecutive period-start strobes are exactly 100 clock cycles apart.
- R2: In every period, the output is high for exactly N cycles, where N = 10*tens + units of the setpoint captured for that period.
- R3: Within a period, the output is high from the first cycle of the period (counter value 00) up to counter value N-1, and low from counter value N to 99. The output can only rise in the first cycle of a period.
- R4: While reset is active, and in the first cycle after reset is released, the counter is at 00, the strobe is low, and the output is high. The one exception: if the captured setpoint is 00, the output is low.
- R5: A setpoint of 00 keeps the output low for the whole period, because clearing takes priority over setting at rollover.
- R6: The setpoint is captured during reset and in the last cycle of each period (counter value 99). A setpoint change at any other time has no effect until the next period.
- R7: A setpoint digit above 9 (codes 0xA to 0xF) is captured as 9. For example, tens=0xA and units=0x5 gives 95.
- R8: The inverted output is the exact complement of the output in every cycle.
- R9: The period-start strobe is high for exactly one cycle: the first cycle after each rollover from 99 to 00. It is not raised for the first period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_tens_i | input | 4 | Setpoint tens digit, BCD |
| sp_units_i | input | 4 | Setpoint units digit, BCD |
| pwm_o | output | 1 | PWM output |
| pwm_n_o | output | 1 | Inverted PWM output |
| period_start_o | output | 1 | One-cycle strobe at each period start |

## Verification
Every output is registered. A setpoint applied during the cycle in which the counter shows 99 takes effect in the very next cycle, when the strobe is high. A setpoint applied during a reset cycle is in effect in the first cycle after reset. The output responds to a counter match in the same cycle in which the counter shows the match value, because the flip-flop decides on the counter's next value. The bench changes its inputs one time unit after the rising edge and compares all three outputs at the falling edge. There, a behavioural model that advanced at the same rising edge predicts the outputs. Once per period, at each strobe, the bench also checks the high-time total and the period length.

// File: rtl/pwm_bcd_pkg.sv
package pwm_bcd_pkg;

    localparam int DIGIT_W    = 4;
    localparam int RADIX      = 10;
    localparam int NUM_DIGITS = 2;
    localparam int PERIOD     = RADIX ** NUM_DIGITS;
    localparam int GAP_W      = $clog2(PERIOD + 1);

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef struct packed {
        bcd_digit_t tens;
        bcd_digit_t units;
    } bcd_pair_t;

    // Reduce an out-of-range code to the largest legal digit.
    function automatic bcd_digit_t clamp_digit(input bcd_digit_t d);
        bcd_digit_t lim;
        lim = bcd_digit_t'(RADIX - 1);
        return (d > lim) ? lim : d;
    endfunction

    function automatic bcd_pair_t clamp_pair(input bcd_pair_t p);
        bcd_pair_t r;
        r.tens  = clamp_digit(p.tens);
        r.units = clamp_digit(p.units);
        return r;
    endfunction

    function automatic logic pair_is_zero(input bcd_pair_t p);
        return (p.tens == '0) && (p.units == '0);
    endfunction

endpackage

// File: rtl/bcd_decade_cnt.sv
module bcd_decade_cnt #(
    parameter int W   = 4,
    parameter int LIM = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] nxt_o,
    output logic         carry_o
);
    localparam logic [W-1:0] TOP = W'(LIM - 1);

    logic [W-1:0] q;

    always_comb begin
        carry_o = en_i && (q == TOP);
        if (!en_i)
            nxt_o = q;
        else if (q == TOP)
            nxt_o = '0;
        else
            nxt_o = W'(q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt_o;
    end

    assign q_o = q;
endmodule

// File: rtl/bcd_setpoint_hold.sv
module bcd_setpoint_hold
    import pwm_bcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  bcd_pair_t raw_i,
    output bcd_pair_t hold_o,
    output bcd_pair_t next_o
);
    bcd_pair_t hold_q;

    // The value in force from the next cycle on.
    always_comb begin
        if (rst || load_i)
            next_o = clamp_pair(raw_i);
        else
            next_o = hold_q;
    end

    always_ff @(posedge clk) begin
        hold_q <= next_o;
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/pwm_sr_stage.sv
module pwm_sr_stage (
    input  logic clk,
    input  logic rst,
    input  logic rst_val_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= rst_val_i;
        else if (clr_i)
            q <= 1'b0;
        else if (set_i)
            q <= 1'b1;
    end

    assign q_o = q;
endmodule

// File: rtl/pwm_bcd_gen.sv
module pwm_bcd_gen
    import pwm_bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] sp_tens_i,
    input  logic [3:0] sp_units_i,
    output logic       pwm_o,
    output logic       pwm_n_o,
    output logic       period_start_o
);
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0] cnt_q;
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0] cnt_nxt;
    logic [NUM_DIGITS:0]                en_chain;

    assign en_chain[0] = 1'b1;

    // Digit 0 is the units digit; each carry enables the next digit up.
    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
            bcd_decade_cnt #(
                .W   (DIGIT_W),
                .LIM (RADIX)
            ) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .en_i    (en_chain[g]),
                .q_o     (cnt_q[g]),
                .nxt_o   (cnt_nxt[g]),
                .carry_o (en_chain[g+1])
            );
        end
    endgenerate

    logic      wrap;
    bcd_pair_t cnt_next_pair;
    bcd_pair_t raw_sp;
    bcd_pair_t sp_hold;
    bcd_pair_t sp_next;
    logic      hit;
    logic      rst_level;
    logic      out_q;
    logic      stb_q;

    assign wrap          = en_chain[NUM_DIGITS];
    assign cnt_next_pair = '{tens: cnt_nxt[1], units: cnt_nxt[0]};
    assign raw_sp        = '{tens: sp_tens_i, units: sp_units_i};

    bcd_setpoint_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (wrap),
        .raw_i  (raw_sp),
        .hold_o (sp_hold),
        .next_o (sp_next)
    );

    // Decide on the next count so the output lines up with the counter.
    assign hit       = (cnt_next_pair == sp_next);
    assign rst_level = !pair_is_zero(sp_next);

    pwm_sr_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .rst_val_i (rst_level),
        .set_i     (wrap),
        .clr_i     (hit),
        .q_o       (out_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            stb_q <= 1'b0;
        else
            stb_q <= wrap;
    end

    assign pwm_o          = out_q;
    assign pwm_n_o        = !out_q;
    assign period_start_o = stb_q;

endmodule

// File: rtl/pwm_bcd_gen_chk.sv
module pwm_bcd_gen_chk
    import pwm_bcd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] sp_tens_i,
    input logic [3:0] sp_units_i,
    input logic       pwm_o,
    input logic       pwm_n_o,
    input logic       period_start_o
);
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= '0;
        else if (period_start_o)
            gap_q <= GAP_W'(1);
        else
            gap_q <= GAP_W'(gap_q + 1'b1);
    end

    p_complement_r8: assert property (@(posedge clk) disable iff (rst)
        pwm_n_o == !pwm_o);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        period_start_o |=> !period_start_o);

    p_period_len_r1: assert property (@(posedge clk) disable iff (rst)
        period_start_o |-> (gap_q == GAP_W'(PERIOD)));

    p_rise_at_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> period_start_o);

    p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
        (period_start_o && $past(sp_tens_i == 4'd0 && sp_units_i == 4'd0))
            |-> !pwm_o);

endmodule

bind pwm_bcd_gen pwm_bcd_gen_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sp_tens_i      (sp_tens_i),
    .sp_units_i     (sp_units_i),
    .pwm_o          (pwm_o),
    .pwm_n_o        (pwm_n_o),
    .period_start_o (period_start_o)
);

// File: tb/pwm_bcd_gen_tb.sv
module pwm_bcd_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tens = 4'd3;
    logic [3:0] units = 4'd6;
    logic       pwm, pwm_n, stb;

    always #2 clk = !clk;

    pwm_bcd_gen u_dut (
        .clk            (clk),
        .rst            (rst),
        .sp_tens_i      (tens),
        .sp_units_i     (units),
        .pwm_o          (pwm),
        .pwm_n_o        (pwm_n),
        .period_start_o (stb)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R4";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clampd(input int d);
        return (d > 9) ? 9 : d;
    endfunction

    // Behavioural reference: period position, captured setpoint, output level.
    int m_cnt = 0, m_hold = 0, m_out = 1, m_stb = 0, m_done_n = 0;

    always @(posedge clk) begin
        int sp, nxt;
        bit wrap;
        sp = 10 * clampd(int'(tens)) + clampd(int'(units));
        if (rst) begin
            m_cnt = 0; m_hold = sp; m_out = (sp != 0); m_stb = 0;
        end else begin
            wrap = (m_cnt == 99);
            if (wrap) begin
                m_done_n = m_hold;
                m_hold   = sp;
            end
            nxt   = wrap ? 0 : m_cnt + 1;
            m_stb = wrap;
            m_cnt = nxt;
            m_out = (m_cnt < m_hold) ? 1 : 0;
        end
    end

    int hi_acc = 0, gap = 0;

    always @(negedge clk) begin
        if (rst) begin
            hi_acc = 0; gap = 0;
        end else begin
            check(pwm === m_out[0], tag, pwm, m_out);
            check(pwm_n === !pwm, "R8", pwm_n, !pwm);
            check(stb === m_stb[0], "R9", stb, m_stb);
            if (stb) begin
                check(hi_acc == m_done_n, (tag == "R6") ? "R6" : "R2", hi_acc, m_done_n);
                check(gap == 100, "R1", gap, 100);
                hi_acc = 0; gap = 0;
            end
            hi_acc += int'(pwm);
            gap++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_sp(input logic [3:0] t, input logic [3:0] u);
        tens = t; units = u;
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R4: reset state with setpoint 36
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        #0;
        check(pwm === 1'b1, "R4", pwm, 1);
        check(stb === 1'b0, "R4", stb, 0);
        tag = "R3";
        cycles(260);
        // R5: zero setpoint
        tag = "R5"; set_sp(4'd0, 4'd0);
        cycles(250);
        // R3: full-scale setpoint
        tag = "R3"; set_sp(4'd9, 4'd9);
        cycles(220);
        tag = "R3"; set_sp(4'd0, 4'd1);
        cycles(220);
        // R7: out-of-range digits
        tag = "R7"; set_sp(4'hA, 4'd5);
        cycles(220);
        set_sp(4'hF, 4'hF);
        cycles(220);
        // R6: mid-period changes must not disturb the running period
        tag = "R6"; set_sp(4'd2, 4'd0);
        @(negedge clk);
        while (!stb) @(negedge clk);
        @(negedge clk);
        while (!stb) @(negedge clk);
        cycles(50);
        set_sp(4'd7, 4'd0);
        cycles(20);
        set_sp(4'd4, 4'd0);
        cycles(230);
        // R4/R5: reset with a zero setpoint keeps the line low
        rst = 1'b1; set_sp(4'd0, 4'd0);
        cycles(3);
        rst = 1'b0; tag = "R5";
        @(negedge clk);
        #0;
        check(pwm === 1'b0, "R4", pwm, 0);
        check(stb === 1'b0, "R4", stb, 0);
        cycles(150);
        tag = "R3"; set_sp(4'd5, 4'd0);
        cycles(220);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule